// File: doc/BRIEF.md
# Decimal/Hex Selectable Adder-Subtractor

A single-digit arithmetic unit with no clock and no state. It adds or subtracts two 4-bit operands together with a one-bit carry-in or borrow-in. A radix select decides whether the operands are plain 4-bit binary values or BCD digits. The result is one 4-bit digit and a carry-or-borrow flag, so several units can be chained digit by digit through that flag.

The arithmetic core is a ripple chain of per-bit adder and subtractor cells. In decimal mode a correction stage follows the chain and folds the binary result back into the range 0 to 9. A separate check raises an error flag when a decimal operand is not a valid BCD digit.

Top module: `radix_addsub`

## Requirements
- R1: With op_i=0 (add) and radix_i=0 (hex), {cy_o, res_o} equals a_i + b_i + cy_i as a 5-bit unsigned value.
- R2: With op_i=1 (subtract) and radix_i=0 (hex), res_o equals (a_i - b_i - cy_i) mod 16, and cy_o is 1 exactly when a_i < b_i + cy_i.
- R3: With op_i=0 and radix_i=1 (decimal), and both operands 0..9: for t = a_i + b_i + cy_i, res_o = t mod 10 and cy_o = 1 exactly when t >= 10.
- R4: With op_i=1 and radix_i=1, and both operands 0..9: for d = a_i - b_i - cy_i, cy_o = 1 exactly when d < 0, and res_o = d + 10 when d < 0, otherwise d.
- R5: err_o is 1 exactly when radix_i=1 and a_i > 9 or b_i > 9. err_o is always 0 when radix_i=0.
- R6: The decimal extremes are corrected: 9+9 with carry-in gives digit 9 and carry 1, and 0-9 with borrow-in gives digit 0 and borrow 1.
- R7: The outputs depend only on the present inputs. The same input word gives the same outputs whatever was applied before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand (minuend when subtracting) |
| b_i | input | 4 | Second operand (subtrahend when subtracting) |
| cy_i | input | 1 | Carry-in when adding, borrow-in when subtracting |
| op_i | input | 1 | 0 = add, 1 = subtract |
| radix_i | input | 1 | 0 = hexadecimal, 1 = decimal (BCD) |
| res_o | output | 4 | Result digit |
| cy_o | output | 1 | Carry-out when adding, borrow-out when subtracting |
| err_o | output | 1 | Decimal operand out of range |

## Verification
Every combination of operands, carry-in, operation and radix is applied, so the hex results (R1, R2) and the decimal results (R3, R4) are compared over all of their inputs. This shows whether the correction fires only where it should: sums of 10 to 15 without a chain carry, sums of 16 and above, and negative differences. Operands of 10 to 15 separate the error flag's decimal behaviour from its hex behaviour (R5). Random words drawn from a fixed seed then revisit the same inputs in a scrambled order to expose any dependence on earlier inputs (R7), and directed words hit the decimal extremes (R6).

// File: rtl/radix_addsub_pkg.sv
package radix_addsub_pkg;
  parameter int unsigned DIGIT_W = 4;
  parameter int unsigned DEC_BASE = 10;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  typedef enum logic {
    RADIX_HEX = 1'b0,
    RADIX_DEC = 1'b1
  } radix_e;
endpackage

// File: rtl/add_bit_cell.sv
module add_bit_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ c_i;
  assign c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
endmodule

// File: rtl/sub_bit_cell.sv
module sub_bit_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic b_i,
  output logic d_o,
  output logic b_o
);
  assign d_o = x_i ^ y_i ^ b_i;
  assign b_o = (~x_i & y_i) | (~x_i & b_i) | (y_i & b_i);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain
  import radix_addsub_pkg::*;
#(
  parameter int unsigned W = DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  input  op_e          op_i,
  output logic [W-1:0] raw_o,
  output logic         co_o
);
  logic [W:0] chain;
  assign chain[0] = ci_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s, c, d, bo;
    add_bit_cell u_add (.x_i(a_i[i]), .y_i(b_i[i]), .c_i(chain[i]), .s_o(s), .c_o(c));
    sub_bit_cell u_sub (.x_i(a_i[i]), .y_i(b_i[i]), .b_i(chain[i]), .d_o(d), .b_o(bo));
    assign raw_o[i]   = (op_i == OP_SUB) ? d  : s;
    assign chain[i+1] = (op_i == OP_SUB) ? bo : c;
  end

  assign co_o = chain[W];

  logic [W:0] ref_sum, ref_dif;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
  assign ref_dif = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, ci_i};

  always_comb begin
    if (op_i == OP_ADD)
      assert_chain_add_R1: assert ({co_o, raw_o} == ref_sum)
        else $error("ripple add mismatch");
    if (op_i == OP_SUB)
      assert_chain_sub_R2: assert ({co_o, raw_o} == ref_dif)
        else $error("ripple sub mismatch");
  end
endmodule

// File: rtl/operand_check.sv
module operand_check
  import radix_addsub_pkg::*;
#(
  parameter int unsigned W = DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  radix_e       radix_i,
  output logic         err_o
);
  localparam logic [W-1:0] MaxDigit = W'(DEC_BASE - 1);

  assign err_o = (radix_i == RADIX_DEC) && ((a_i > MaxDigit) || (b_i > MaxDigit));
endmodule

// File: rtl/dec_fixup.sv
module dec_fixup
  import radix_addsub_pkg::*;
#(
  parameter int unsigned W = DIGIT_W
) (
  input  logic [W-1:0] raw_i,
  input  logic         raw_co_i,
  input  op_e          op_i,
  input  radix_e       radix_i,
  input  logic         err_i,
  output logic [W-1:0] res_o,
  output logic         co_o
);
  localparam logic [W-1:0] MaxDigit = W'(DEC_BASE - 1);
  localparam logic [W-1:0] Adj      = W'((1 << W) - DEC_BASE);

  logic need_fix;
  logic [W-1:0] fixed;

  // add: out of digit range or chain carry; sub: any borrow
  assign need_fix = (op_i == OP_ADD) ? (raw_co_i | (raw_i > MaxDigit)) : raw_co_i;
  assign fixed    = (op_i == OP_ADD) ? (raw_i + Adj) : (raw_i - Adj);

  always_comb begin
    if (radix_i == RADIX_DEC) begin
      res_o = need_fix ? fixed : raw_i;
      co_o  = need_fix;
    end else begin
      res_o = raw_i;
      co_o  = raw_co_i;
    end
  end

  always_comb begin
    if (radix_i == RADIX_DEC && !err_i && op_i == OP_ADD)
      assert_dec_add_digit_R3: assert (res_o <= MaxDigit)
        else $error("decimal sum digit out of range");
    if (radix_i == RADIX_DEC && !err_i && op_i == OP_SUB)
      assert_dec_sub_digit_R4: assert (res_o <= MaxDigit)
        else $error("decimal difference digit out of range");
    if (radix_i == RADIX_HEX)
      assert_hex_passthru_R1: assert (res_o == raw_i && co_o == raw_co_i)
        else $error("hex result altered");
  end
endmodule

// File: rtl/radix_addsub.sv
module radix_addsub
  import radix_addsub_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cy_i,
  input  logic       op_i,
  input  logic       radix_i,
  output logic [3:0] res_o,
  output logic       cy_o,
  output logic       err_o
);
  localparam int unsigned W = DIGIT_W;

  op_e    op;
  radix_e radix;
  logic [W-1:0] raw;
  logic raw_co;

  assign op    = op_e'(op_i);
  assign radix = radix_e'(radix_i);

  ripple_chain #(.W(W)) u_chain (
    .a_i(a_i), .b_i(b_i), .ci_i(cy_i), .op_i(op), .raw_o(raw), .co_o(raw_co)
  );

  operand_check #(.W(W)) u_check (
    .a_i(a_i), .b_i(b_i), .radix_i(radix), .err_o(err_o)
  );

  dec_fixup #(.W(W)) u_fix (
    .raw_i(raw), .raw_co_i(raw_co), .op_i(op), .radix_i(radix), .err_i(err_o),
    .res_o(res_o), .co_o(cy_o)
  );

  always_comb begin
    if (radix == RADIX_HEX)
      assert_no_hex_err_R5: assert (!err_o) else $error("error flag in hex mode");
  end
endmodule

// File: tb/radix_addsub_tb_top.sv
module radix_addsub_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] a, b, res;
  logic cy, op, radix, cy_out, err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  radix_addsub dut_i (
    .a_i(a), .b_i(b), .cy_i(cy), .op_i(op), .radix_i(radix),
    .res_o(res), .cy_o(cy_out), .err_o(err)
  );

  // returns {err, carry, digit}
  function automatic logic [5:0] model(int av, int bv, int cv, int ov, int rv);
    int t;
    logic e;
    e = (rv == 1) && (av > 9 || bv > 9);
    if (rv == 0) begin
      if (ov == 0) begin t = av + bv + cv; return {1'b0, t >= 16, 4'(t)}; end
      t = av - bv - cv; return {1'b0, t < 0, 4'(t + 16)};
    end
    if (ov == 0) begin t = av + bv + cv; return {e, t >= 10, 4'(t % 10)}; end
    t = av - bv - cv;
    return {e, t < 0, 4'((t < 0) ? t + 10 : t)};
  endfunction

  function automatic string tag(int ov, int rv);
    if (rv == 0) return (ov == 0) ? "R1" : "R2";
    return (ov == 0) ? "R3" : "R4";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s a=%0d b=%0d cy=%0d op=%0d radix=%0d act=%0d exp=%0d",
               req, what, a, b, cy, op, radix, act, exp);
    end
  endtask

  task automatic run(int av, int bv, int cv, int ov, int rv, string req_over);
    logic [5:0] e;
    string req;
    @(posedge clk);
    a = 4'(av); b = 4'(bv); cy = 1'(cv); op = 1'(ov); radix = 1'(rv);
    @(negedge clk);
    e = model(av, bv, cv, ov, rv);
    req = (req_over != "") ? req_over : tag(ov, rv);
    check("R5", "err", int'(err), int'(e[5]));
    if (!e[5]) begin
      check(req, "res", int'(res), int'(e[3:0]));
      check(req, "cy", int'(cy_out), int'(e[4]));
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    a = '0; b = '0; cy = 1'b0; op = 1'b0; radix = 1'b0;
    // all-zero idle word
    run(0, 0, 0, 0, 0, "R1");
    // directed decimal extremes
    run(9, 9, 1, 0, 1, "R6");
    run(0, 9, 1, 1, 1, "R6");
    run(5, 5, 0, 0, 1, "R3");
    run(15, 15, 1, 0, 0, "R1");
    run(0, 15, 1, 1, 0, "R2");
    run(10, 3, 0, 0, 1, "R5");
    // exhaustive sweep
    for (int rv = 0; rv < 2; rv++)
      for (int ov = 0; ov < 2; ov++)
        for (int cv = 0; cv < 2; cv++)
          for (int av = 0; av < 16; av++)
            for (int bv = 0; bv < 16; bv++)
              run(av, bv, cv, ov, rv, "");
    // scrambled revisit: history independence
    for (int n = 0; n < 600; n++)
      run(int'($urandom_range(15)), int'($urandom_range(15)), int'($urandom_range(1)),
          int'($urandom_range(1)), int'($urandom_range(1)), "R7");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule